// File: doc/BRIEF.md
# Two-Dimensional Bias Lookup Controller

This block sets the 8-bit wiper code of two bias potentiometers. Each channel has two tables. A base table is indexed by die temperature. An offset table is indexed by a drain reading. The wiper code is the unsigned base plus the signed offset, clamped to the range 0 to 255. Both indexes move in steps and carry hysteresis, so a reading that sits on a step edge does not make the wiper chatter.

An upstream converter supplies the temperature, one shared drain-voltage reading and one drain-current reading per channel. It pulses `round_done_i` once after every full conversion round. The tables are plain register arrays. A single-cycle write port fills them. The wipers change only on an enabled round pulse. Software can freeze them, or it can take over both indexes by hand.

Top module: `bias_lut_ctrl`

## Requirements
- R1: After reset the temperature index and both drain indexes are 0, and both wipers read 0. The wipers keep that value until the first enabled round pulse, even while the tables are being written.
- R2: `temp_i` is two's complement in units of 1/256 °C. On an upward move the temperature index becomes floor((T + 40 °C) / 2 °C). The result is clamped: any T at or below -40 °C gives 0, and any T at or above +102 °C gives 71.
- R3: The temperature index k moves down only when T drops below (-40 + 2k - 1) °C. A reading exactly 1 °C under the boundary of k keeps index k.
- R4: When a channel takes its drain index from the voltage reading, the index is (V - 8000h) / 0200h, rounded down. A reading at or below 8000h gives 0, and a reading at or above FE00h gives 63.
- R5: When a channel takes its drain index from its own current reading, the index is I / 0200h, rounded down. A reading at or above 7E00h gives 63.
- R6: A drain index k moves down only when the reading, measured from the source base, falls below k*0200h - 0100h. It moves up as soon as the plain quotient exceeds k.
- R7: Bit c of `drain_sel_i` set to 1 makes channel c use `vdrain_i`. Set to 0, the channel uses its own slice of `idrain_i`. The source that is not selected has no effect on the wiper.
- R8: The wiper is the temperature entry (unsigned) plus the drain entry (signed, -128 to +127). A sum above 255 gives 255, and a sum below 0 gives 0.
- R9: Indexes and wipers load only in a cycle where `round_done_i` and `update_en_i` are both 1. In every other cycle they hold, whatever the readings do.
- R10: With `index_en_i` set, an enabled round pulse loads the temperature index from `man_tidx_i`, clamped to 71. Each drain index loads from its 6-bit slice of `man_didx_i`. Hysteresis is bypassed.
- R11: Write-port code: MSB of `wr_tbl_i` = 0 selects a temperature table and 1 selects a drain table. The low bit selects the channel. If a write lands in the same cycle as an enabled round pulse, that pulse uses the old entry, and the new entry takes effect from the next pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| temp_i | input | 16 | Temperature, two's complement, 1/256 °C per LSB |
| vdrain_i | input | 16 | Shared drain-voltage reading |
| idrain_i | input | 32 | Drain-current readings, channel c in bits [16c+15:16c] |
| round_done_i | input | 1 | One-cycle pulse at the end of a conversion round |
| update_en_i | input | 1 | 1 lets round pulses update; 0 freezes |
| index_en_i | input | 1 | 1 takes both indexes from the manual inputs |
| drain_sel_i | input | 2 | Per-channel drain source: 1 voltage, 0 current |
| man_tidx_i | input | 7 | Manual temperature index |
| man_didx_i | input | 12 | Manual drain indexes, channel c in bits [6c+5:6c] |
| wr_en_i | input | 1 | Table write strobe |
| wr_tbl_i | input | 2 | Table code, see R11 |
| wr_addr_i | input | 7 | Table entry |
| wr_data_i | input | 8 | Entry data |
| wiper_o | output | 16 | Wiper codes, channel c in bits [8c+7:8c] |

## Verification
A table write and an enabled round update can occur in the same cycle. The bench provokes this by driving a write to the drain entry that is currently selected, in the very cycle it raises the round pulse. It then checks two things: the wiper produced by that pulse still reflects the old entry, and the next pulse reflects the new one. A second overlap happens inside the index logic. There the upward quotient and the hysteresis-shifted quotient are judged together, and readings placed exactly on a boundary, and exactly one hysteresis width below it, show which of the two governs.

// File: rtl/bias_lut_pkg.sv
package bias_lut_pkg;
  localparam int RD_W    = 16;        // reading width
  localparam int X_W     = 18;        // signed working width
  localparam int T_DEPTH = 72;
  localparam int D_DEPTH = 64;
  localparam int T_IW    = $clog2(T_DEPTH);
  localparam int D_IW    = $clog2(D_DEPTH);
  localparam int ENT_W   = 8;
  localparam int STEP_LG = 9;         // 2 degC = 512 LSB, drain step 0200h
  localparam int T_BASE  = -10240;    // -40 degC
  localparam int T_HYST  = 256;       // 1 degC
  localparam int DV_BASE = 32768;     // 8000h
  localparam int D_HYST  = 256;       // 0100h
endpackage

// File: rtl/bias_step_index.sv
module bias_step_index #(
  parameter int XW      = 18,
  parameter int BASE    = 0,
  parameter int STEP_LG = 9,
  parameter int HYST    = 256,
  parameter int DEPTH   = 64,
  parameter int IW      = $clog2(DEPTH)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic signed [XW-1:0] x_i,
  input  logic                 load_i,
  input  logic                 man_en_i,
  input  logic [IW-1:0]        man_idx_i,
  output logic [IW-1:0]        nxt_o,
  output logic [IW-1:0]        idx_o
);
  localparam int TOP = DEPTH - 1;

  function automatic logic [IW-1:0] quant(input int x);
    int d;
    int q;
    d = x - BASE;
    if (d < 0) return '0;
    q = d >>> STEP_LG;
    if (q > TOP) return IW'(TOP);
    return IW'(q);
  endfunction

  logic [IW-1:0] raw_up, raw_dn;

  always_comb begin
    raw_up = quant(int'(x_i));
    raw_dn = quant(int'(x_i) + HYST);
    if (man_en_i)
      nxt_o = (int'(man_idx_i) > TOP) ? IW'(TOP) : man_idx_i;
    else if (raw_up > idx_o)
      nxt_o = raw_up;
    else if (raw_dn < idx_o)
      nxt_o = raw_dn;
    else
      nxt_o = idx_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     idx_o <= '0;
    else if (load_i) idx_o <= nxt_o;
  end
endmodule

// File: rtl/bias_lut_chan.sv
module bias_lut_chan #(
  parameter int T_DEPTH = 72,
  parameter int D_DEPTH = 64,
  parameter int EW      = 8,
  parameter int T_IW    = $clog2(T_DEPTH),
  parameter int D_IW    = $clog2(D_DEPTH)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_t_i,
  input  logic            wr_d_i,
  input  logic [T_IW-1:0] wr_addr_i,
  input  logic [EW-1:0]   wr_data_i,
  input  logic            load_i,
  input  logic [T_IW-1:0] t_idx_i,
  input  logic [D_IW-1:0] d_idx_i,
  output logic [EW-1:0]   wiper_o
);
  localparam int SW   = EW + 2;
  localparam int WMAX = (1 << EW) - 1;

  logic [EW-1:0] t_tbl [T_DEPTH];
  logic [EW-1:0] d_tbl [D_DEPTH];
  logic [EW-1:0] base, offs;
  logic signed [SW-1:0] sum;
  logic [EW-1:0] sat;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < T_DEPTH; i++) t_tbl[i] <= '0;
      for (int i = 0; i < D_DEPTH; i++) d_tbl[i] <= '0;
    end else begin
      if (wr_t_i && int'(wr_addr_i) < T_DEPTH) t_tbl[wr_addr_i] <= wr_data_i;
      if (wr_d_i && int'(wr_addr_i) < D_DEPTH) d_tbl[wr_addr_i[D_IW-1:0]] <= wr_data_i;
    end
  end

  // read with the incoming index: old contents if a write shares the cycle
  always_comb begin
    base = t_tbl[t_idx_i];
    offs = d_tbl[d_idx_i];
    sum  = $signed({2'b00, base}) + $signed({{2{offs[EW-1]}}, offs});
    if (sum < 0)                      sat = '0;
    else if (sum > SW'(WMAX))         sat = EW'(WMAX);
    else                              sat = sum[EW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     wiper_o <= '0;
    else if (load_i) wiper_o <= sat;
  end
endmodule

// File: rtl/bias_lut_ctrl.sv
module bias_lut_ctrl
  import bias_lut_pkg::*;
#(
  parameter int NCH = 2,
  parameter int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [RD_W-1:0]      temp_i,
  input  logic [RD_W-1:0]      vdrain_i,
  input  logic [NCH*RD_W-1:0]  idrain_i,
  input  logic                 round_done_i,
  input  logic                 update_en_i,
  input  logic                 index_en_i,
  input  logic [NCH-1:0]       drain_sel_i,
  input  logic [T_IW-1:0]      man_tidx_i,
  input  logic [NCH*D_IW-1:0]  man_didx_i,
  input  logic                 wr_en_i,
  input  logic [CHW:0]         wr_tbl_i,
  input  logic [T_IW-1:0]      wr_addr_i,
  input  logic [ENT_W-1:0]     wr_data_i,
  output logic [NCH*ENT_W-1:0] wiper_o
);
  logic                 upd;
  logic signed [X_W-1:0] t_x;
  logic [T_IW-1:0]      t_nxt, t_idx;

  assign upd = round_done_i & update_en_i;
  assign t_x = $signed({{(X_W-RD_W){temp_i[RD_W-1]}}, temp_i});

  bias_step_index #(
    .XW(X_W), .BASE(T_BASE), .STEP_LG(STEP_LG), .HYST(T_HYST), .DEPTH(T_DEPTH), .IW(T_IW)
  ) u_tidx (
    .clk_i, .rst_ni, .x_i(t_x), .load_i(upd), .man_en_i(index_en_i),
    .man_idx_i(man_tidx_i), .nxt_o(t_nxt), .idx_o(t_idx)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic signed [X_W-1:0] d_x;
    logic [D_IW-1:0]       d_nxt, d_idx;
    logic                  wr_sel;

    // voltage source rebased so both sources quantize from zero
    assign d_x = drain_sel_i[c]
               ? $signed({{(X_W-RD_W){1'b0}}, vdrain_i}) - $signed(X_W'(DV_BASE))
               : $signed({{(X_W-RD_W){1'b0}}, idrain_i[c*RD_W +: RD_W]});
    assign wr_sel = wr_en_i && (wr_tbl_i[CHW-1:0] == CHW'(c));

    bias_step_index #(
      .XW(X_W), .BASE(0), .STEP_LG(STEP_LG), .HYST(D_HYST), .DEPTH(D_DEPTH), .IW(D_IW)
    ) u_didx (
      .clk_i, .rst_ni, .x_i(d_x), .load_i(upd), .man_en_i(index_en_i),
      .man_idx_i(man_didx_i[c*D_IW +: D_IW]), .nxt_o(d_nxt), .idx_o(d_idx)
    );

    bias_lut_chan #(
      .T_DEPTH(T_DEPTH), .D_DEPTH(D_DEPTH), .EW(ENT_W), .T_IW(T_IW), .D_IW(D_IW)
    ) u_chan (
      .clk_i, .rst_ni,
      .wr_t_i(wr_sel && !wr_tbl_i[CHW]), .wr_d_i(wr_sel && wr_tbl_i[CHW]),
      .wr_addr_i, .wr_data_i, .load_i(upd),
      .t_idx_i(t_nxt), .d_idx_i(d_nxt),
      .wiper_o(wiper_o[c*ENT_W +: ENT_W])
    );
  end
endmodule

// File: rtl/bias_lut_ctrl_chk.sv
module bias_lut_ctrl_chk
  import bias_lut_pkg::*;
#(
  parameter int NCH = 2
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 round_done_i,
  input logic                 update_en_i,
  input logic                 index_en_i,
  input logic [RD_W-1:0]      temp_i,
  input logic [T_IW-1:0]      man_tidx_i,
  input logic [T_IW-1:0]      t_idx,
  input logic [NCH*ENT_W-1:0] wiper_o
);
  logic                  upd;
  logic signed [X_W-1:0] t_ext;
  assign upd   = round_done_i && update_en_i;
  assign t_ext = $signed({{(X_W-RD_W){temp_i[RD_W-1]}}, temp_i});

  a_r9_hold_wiper: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd |=> $stable(wiper_o));

  a_r9_hold_tidx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd |=> $stable(t_idx));

  a_r2_rise_rule: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd && !index_en_i) |=>
      (t_idx <= $past(t_idx)) ||
      (int'($past(t_ext)) >= T_BASE + (int'(t_idx) << STEP_LG)));

  a_r3_fall_rule: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd && !index_en_i) |=>
      (t_idx >= $past(t_idx)) ||
      (int'($past(t_ext)) < T_BASE + (int'($past(t_idx)) << STEP_LG) - T_HYST));

  a_r10_manual_tidx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd && index_en_i) |=>
      t_idx == ((int'($past(man_tidx_i)) > T_DEPTH - 1) ? T_IW'(T_DEPTH - 1) : $past(man_tidx_i)));
endmodule

bind bias_lut_ctrl bias_lut_ctrl_chk #(.NCH(NCH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .round_done_i(round_done_i),
  .update_en_i(update_en_i), .index_en_i(index_en_i), .temp_i(temp_i),
  .man_tidx_i(man_tidx_i), .t_idx(t_idx), .wiper_o(wiper_o)
);

// File: tb/bias_lut_ctrl_test.sv
`timescale 1ns/1ps
module bias_lut_ctrl_test;
  logic        clk = 0;
  logic        rst_ni = 0;
  logic [15:0] temp = 0, vdrain = 0;
  logic [31:0] idrain = 0;
  logic        round_done = 0, update_en = 1, index_en = 0;
  logic [1:0]  drain_sel = 0;
  logic [6:0]  man_tidx = 0;
  logic [11:0] man_didx = 0;
  logic        wr_en = 0;
  logic [1:0]  wr_tbl = 0;
  logic [6:0]  wr_addr = 0;
  logic [7:0]  wr_data = 0;
  logic [15:0] wiper;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  bias_lut_ctrl uut (
    .clk_i(clk), .rst_ni(rst_ni), .temp_i(temp), .vdrain_i(vdrain), .idrain_i(idrain),
    .round_done_i(round_done), .update_en_i(update_en), .index_en_i(index_en),
    .drain_sel_i(drain_sel), .man_tidx_i(man_tidx), .man_didx_i(man_didx),
    .wr_en_i(wr_en), .wr_tbl_i(wr_tbl), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .wiper_o(wiper)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0d exp=%0d", req, got, exp);
    end
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic wr(input logic [1:0] tbl, input int addr, input logic [7:0] data);
    @(negedge clk);
    wr_en = 1; wr_tbl = tbl; wr_addr = 7'(addr); wr_data = data;
    @(negedge clk);
    wr_en = 0;
  endtask

  // wiper loads on the posedge between the two negedges
  task automatic strobe();
    @(negedge clk) round_done = 1;
    @(negedge clk) round_done = 0;
  endtask

  task automatic temp_step(input int t, input int exp, input string req);
    temp = 16'(t);
    strobe();
    chk(req, wiper[7:0], 8'(exp));
  endtask

  task automatic drain_step(input logic [15:0] v, input logic [15:0] i, input int exp, input string req);
    vdrain = v; idrain[31:16] = i;
    strobe();
    chk(req, wiper[15:8], 8'(100 + exp));
  endtask

  task automatic t_reset();
    chk("R1 wiper0 after reset", wiper[7:0], 0);
    chk("R1 wiper1 after reset", wiper[15:8], 0);
    // ch0: base = index, offset 0; ch1: base 100, offset = index
    for (int k = 0; k < 72; k++) wr(2'd0, k, 8'(k));
    for (int k = 0; k < 72; k++) wr(2'd1, k, 8'd100);
    for (int k = 0; k < 64; k++) wr(2'd3, k, 8'(k));
    repeat (3) @(negedge clk);
    chk("R1 wiper0 held while tables load", wiper[7:0], 0);
    chk("R1 wiper1 held while tables load", wiper[15:8], 0);
  endtask

  task automatic t_temp_map();
    temp_step(0, 20, "R2 0C");
    temp_step(6400, 32, "R2 25C");
    temp_step(26112, 71, "R2 102C clamp");
    temp_step(16'h7FFF, 71, "R2 max clamp");
    temp_step(16'h8000, 0, "R2 min clamp");
    temp_step(-9728, 1, "R2 -38C");
    temp_step(-15360, 0, "R2 -60C clamp");
    temp_step(-10240, 0, "R2 -40C");
  endtask

  task automatic t_temp_hyst();
    temp_step(6400, 32, "R3 set 25C");
    temp_step(5888, 32, "R3 exactly 1C under edge holds");
    temp_step(5862, 31, "R3 below hysteresis drops");
    temp_step(6118, 31, "R3 just under edge no rise");
    temp_step(6144, 32, "R3 on edge rises");
  endtask

  task automatic t_drain_cur();
    drain_sel = 2'b00;
    drain_step(16'h0000, 16'h0000, 0, "R5 zero");
    drain_step(16'h0000, 16'h1234, 9, "R5 mid");
    drain_step(16'h0000, 16'h1180, 9, "R6 inside hysteresis holds");
    drain_step(16'h0000, 16'h10FF, 8, "R6 below hysteresis drops");
    drain_step(16'h0000, 16'h7E00, 63, "R5 7E00 top");
    drain_step(16'h0000, 16'hFFFF, 63, "R5 clamp");
  endtask

  task automatic t_drain_volt();
    drain_sel = 2'b10;
    drain_step(16'h7000, 16'hFFFF, 0, "R4 below 8000h");
    drain_step(16'h8200, 16'hFFFF, 1, "R4 8200h");
    drain_step(16'hFE00, 16'h0000, 63, "R4 FE00h top");
    drain_step(16'hFFFF, 16'h0000, 63, "R4 clamp");
    drain_step(16'hA123, 16'h0000, 17, "R6 voltage fall");
    drain_step(16'h8000, 16'h7E00, 0, "R7 current ignored when voltage selected");
    drain_sel = 2'b00;
    drain_step(16'hFE00, 16'h0400, 2, "R7 voltage ignored when current selected");
  endtask

  task automatic t_freeze();
    temp_step(6400, 32, "R9 baseline");
    update_en = 0;
    temp = 16'(-15360); idrain[31:16] = 16'h7E00;
    strobe();
    chk("R9 wiper0 frozen", wiper[7:0], 32);
    chk("R9 wiper1 frozen", wiper[15:8], 102);
    update_en = 1;
    repeat (4) @(negedge clk);
    chk("R9 no pulse no change", wiper[7:0], 32);
    strobe();
    chk("R9 resumes", wiper[7:0], 0);
    chk("R9 resumes ch1", wiper[15:8], 163);
  endtask

  task automatic t_manual();
    index_en = 1; temp = 16'd6400;
    man_tidx = 7'd5; man_didx = {6'd40, 6'd3};
    strobe();
    chk("R10 manual temp index", wiper[7:0], 5);
    chk("R10 manual drain index", wiper[15:8], 140);
    man_tidx = 7'd100;
    strobe();
    chk("R10 manual clamp", wiper[7:0], 71);
  endtask

  task automatic t_saturate();
    wr(2'd2, 3, 8'd127);
    strobe();
    chk("R8 plain sum", wiper[7:0], 198);
    wr(2'd0, 71, 8'd200);
    strobe();
    chk("R8 high clamp", wiper[7:0], 255);
    wr(2'd2, 3, 8'h80);
    strobe();
    chk("R8 negative offset", wiper[7:0], 72);
    wr(2'd0, 71, 8'd100);
    strobe();
    chk("R8 low clamp", wiper[7:0], 0);
    wr(2'd0, 71, 8'd200);
    wr(2'd2, 3, 8'hCE);
    strobe();
    chk("R8 signed sum", wiper[7:0], 150);
  endtask

  task automatic t_collision();
    @(negedge clk);
    wr_en = 1; wr_tbl = 2'd2; wr_addr = 7'd3; wr_data = 8'd10; round_done = 1;
    @(negedge clk);
    wr_en = 0; round_done = 0;
    chk("R11 same-cycle write unseen", wiper[7:0], 150);
    strobe();
    chk("R11 write seen next pulse", wiper[7:0], 210);
    chk("R11 other channel untouched", wiper[15:8], 140);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog got=timeout exp=done");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    t_reset();
    t_temp_map();
    t_temp_hyst();
    t_drain_cur();
    t_drain_volt();
    t_freeze();
    t_manual();
    t_saturate();
    t_collision();
    finish_run();
  end
endmodule